// File: doc/BRIEF.md
# Host-Signal Edge Interrupt Controller

This block watches four active-low control lines driven by a host across an IEEE 1284 style parallel port: select-in, strobe, auto-feed and init. Each line is brought into the local clock domain through a two-flop synchroniser. Rising and falling transitions on each line are then detected separately and recorded in an 8-bit pending register.

An 8-bit enable register selects which pending events may raise the single level-sensitive CPU interrupt. Software reaches both registers over a byte-wide register bus with combinational read data. After servicing an event, software clears it by writing zero to its bit. Writing one to a pending bit does nothing, so an event cannot be raised from software.

For the first cycles after reset, edge detection is held off. Whatever level a host line carries when reset is released is therefore taken as its starting state and is not reported as an event.

Top module: `hostedge_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the pending register reads 0x00 and `irq_o` is 0.
- R2: Pending bit 2i records a low-to-high change of line i, and bit 2i+1 records a high-to-low change of line i. The line order is select-in = 0, strobe = 1, auto-feed = 2, init = 3. A change applied to a host input shows in the pending register three clock edges later.
- R3: A pending bit sets on its edge whether or not the matching enable bit is set.
- R4: `irq_o` is a registered OR over all 8 bits of (pending AND enable), so it follows the register contents one cycle later. It stays 1 for as long as any enabled pending bit remains set.
- R5: A bus write to the pending address clears every bit for which the written data bit is 0. Bits written as 1 keep their current value and are never set by the write.
- R6: If an edge and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R7: The enable register sits at byte address 0x66 and the pending register at 0x68. The enable register takes written data as is, and both registers read back their current contents.
- R8: A read of any other address returns 0x00. A write to any other address changes neither register.
- R9: A host line level held through reset release sets no pending bit during the settle window. The first change after the window is recorded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_n_i | input | 1 | Host select-in line (active low, asynchronous) |
| host_stb_n_i | input | 1 | Host strobe line (active low, asynchronous) |
| host_afd_n_i | input | 1 | Host auto-feed line (active low, asynchronous) |
| host_init_n_i | input | 1 | Host init line (active low, asynchronous) |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
Each host line in turn is first pulled low and then released, with all enables off. This shows that each line and each direction lands on its own bit, that no neighbouring bit moves, and that pending does not depend on enable. Clearing writes that mix 0 and 1 bits separate a write-zero-to-clear rule from a write-one-to-clear or plain overwrite rule. A second falling edge timed to land in the same cycle as a clear of the whole register tells edge priority apart from write priority. The interrupt is probed with the enable set both before and after the event, and again after a partial clear, to confirm that it is a registered level and not a pulse. A reset taken with a line already low checks that a held level is not mistaken for an edge.

// File: rtl/hostedge_pkg.sv
package hostedge_pkg;
  typedef enum logic [1:0] {
    LN_SEL  = 2'd0,
    LN_STB  = 2'd1,
    LN_AFD  = 2'd2,
    LN_INIT = 2'd3
  } line_e;

  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned EVT_W     = 2 * NUM_LINES;

  // even bit: low-to-high, odd bit: high-to-low
  function automatic int unsigned rise_bit(input int unsigned line);
    return 2 * line;
  endfunction

  function automatic int unsigned fall_bit(input int unsigned line);
    return 2 * line + 1;
  endfunction
endpackage

// File: rtl/hostedge_sync.sv
module hostedge_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= {WIDTH{RST_V}};
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {WIDTH{RST_V}};
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/hostedge_detect.sv
module hostedge_detect #(
  parameter int unsigned LINES       = 4,
  parameter int unsigned HOLD_CYCLES = 4,
  localparam int unsigned EW         = 2 * LINES,
  localparam int unsigned CW         = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  output logic [EW-1:0]    edge_o
);
  import hostedge_pkg::*;

  logic [LINES-1:0] prev_q;
  logic [CW-1:0]    hold_cnt_q;
  logic             armed;

  assign armed = (hold_cnt_q == CW'(HOLD_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '1;
      hold_cnt_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (!armed) hold_cnt_q <= hold_cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign edge_o[rise_bit(i)] = armed & ~prev_q[i] &  lvl_i[i];
    assign edge_o[fall_bit(i)] = armed &  prev_q[i] & ~lvl_i[i];
  end
endmodule

// File: rtl/hostedge_regs.sv
module hostedge_regs #(
  parameter int unsigned     ADDR_W    = 8,
  parameter int unsigned     EVT_W     = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 8'h66,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h68
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_W-1:0]  edge_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [EVT_W-1:0]  wdata_i,
  output logic [EVT_W-1:0]  rdata_o,
  output logic              irq_o
);
  logic [EVT_W-1:0] en_q, pend_q, pend_d, keep_mask;
  logic             wr_en, wr_pend, irq_q;

  assign wr_en   = wr_i && (addr_i == EN_ADDR);
  assign wr_pend = wr_i && (addr_i == PEND_ADDR);

  // write of 0 clears, write of 1 keeps; edges override the clear
  assign keep_mask = wr_pend ? wdata_i : '1;
  assign pend_d    = (pend_q & keep_mask) | edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) en_q <= wdata_i;
      pend_q <= pend_d;
      irq_q  <= |(pend_q & en_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == EN_ADDR)        rdata_o = en_q;
    else if (addr_i == PEND_ADDR) rdata_o = pend_q;
  end

  assign irq_o = irq_q;

  // R4: request rises only after an enabled pending pair existed
  a_r4_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past((pend_q & en_q) != '0));
  // R4: no enabled pending pair means no request next cycle
  a_r4_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & en_q) == '0) |=> !irq_q);
  // R5: a pending bit only rises through an edge
  a_r5_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(edge_i)) == '0));
  // R5: a pending bit only falls through a pending write
  a_r5_clear_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  // R6: a detected edge always leaves its bit set
  a_r6_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i != '0) |=> ((pend_q & $past(edge_i)) == $past(edge_i)));
  // R8: enable register only moves on a write to its own address
  a_r8_en_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/hostedge_irq_ctrl.sv
module hostedge_irq_ctrl #(
  parameter int unsigned       ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] EN_ADDR       = 8'h66,
  parameter logic [ADDR_W-1:0] PEND_ADDR     = 8'h68,
  parameter int unsigned       SYNC_STAGES   = 2,
  parameter int unsigned       SETTLE_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_n_i,
  input  logic              host_stb_n_i,
  input  logic              host_afd_n_i,
  input  logic              host_init_n_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  import hostedge_pkg::*;

  // hold-off covers the synchroniser fill plus the settle window
  localparam int unsigned HOLD_CYCLES = SYNC_STAGES + SETTLE_CYCLES;

  logic [NUM_LINES-1:0] host_raw, host_sync;
  logic [EVT_W-1:0]     edges;

  always_comb begin
    host_raw          = '1;
    host_raw[LN_SEL]  = host_sel_n_i;
    host_raw[LN_STB]  = host_stb_n_i;
    host_raw[LN_AFD]  = host_afd_n_i;
    host_raw[LN_INIT] = host_init_n_i;
  end

  hostedge_sync #(
    .WIDTH (NUM_LINES),
    .STAGES(SYNC_STAGES),
    .RST_V (1'b1)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(host_raw),
    .sync_o (host_sync)
  );

  hostedge_detect #(
    .LINES      (NUM_LINES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) i_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (host_sync),
    .edge_o(edges)
  );

  hostedge_regs #(
    .ADDR_W   (ADDR_W),
    .EVT_W    (EVT_W),
    .EN_ADDR  (EN_ADDR),
    .PEND_ADDR(PEND_ADDR)
  ) i_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edges),
    .addr_i (bus_addr_i),
    .wr_i   (bus_wr_i),
    .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/test_hostedge_irq_ctrl.sv
`timescale 1ns/1ps
module test_hostedge_irq_ctrl;
  localparam logic [7:0] A_EN   = 8'h66;
  localparam logic [7:0] A_PEND = 8'h68;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] line_n = 4'hF;
  logic [7:0] addr = 8'h00;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;

  hostedge_irq_ctrl i_hostedge_irq_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .host_sel_n_i (line_n[0]),
    .host_stb_n_i (line_n[1]),
    .host_afd_n_i (line_n[2]),
    .host_init_n_i(line_n[3]),
    .bus_addr_i   (addr),
    .bus_wr_i     (wr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_o        (irq)
  );

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {7'd0, irq} : rdata;
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic exp_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk); #1;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic set_line(input int ln, input logic v);
    @(negedge clk);
    line_n[ln] = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    // R1
    exp_rd(A_EN, 8'h00, "R1 enable reset");
    exp_rd(A_PEND, 8'h00, "R1 pending reset");
    exp_irq(1'b0, "R1 irq reset");

    // R7 / R8
    bus_wr(A_EN, 8'hA5);
    exp_rd(A_EN, 8'hA5, "R7 enable readback");
    exp_rd(8'h67, 8'h00, "R8 unmapped read");
    bus_wr(8'h70, 8'hFF);
    bus_wr(8'h67, 8'h3C);
    exp_rd(A_EN, 8'hA5, "R8 stray write kept enable");
    exp_rd(A_PEND, 8'h00, "R8 stray write kept pending");
    bus_wr(A_EN, 8'h00);
    exp_rd(A_EN, 8'h00, "R7 enable cleared");

    // R2 / R3: each line, each direction, enables off
    for (int ln = 0; ln < 4; ln++) begin
      set_line(ln, 1'b0);
      exp_rd(A_PEND, 8'(1 << (2*ln+1)), $sformatf("R2 R3 line %0d fall", ln));
      exp_irq(1'b0, "R4 no irq while disabled");
      bus_wr(A_PEND, 8'h00);
      set_line(ln, 1'b1);
      exp_rd(A_PEND, 8'(1 << (2*ln)), $sformatf("R2 R3 line %0d rise", ln));
      bus_wr(A_PEND, 8'h00);
      exp_rd(A_PEND, 8'h00, "R5 full clear");
    end

    // R2 latency: visible after third clock edge, not second
    @(negedge clk);
    line_n[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    addr = A_PEND; #1;
    n_vec++;
    if (rdata !== 8'h00) begin
      n_bad++; $display("FAIL R2 early capture: got %02h expected 00", rdata);
    end
    @(negedge clk); #1;
    n_vec++;
    if (rdata !== 8'h08) begin
      n_bad++; $display("FAIL R2 capture on third edge: got %02h expected 08", rdata);
    end

    // R5: write one keeps, write zero clears selectively
    set_line(2, 1'b0);                         // adds bit5
    exp_rd(A_PEND, 8'h28, "R5 two events pending");
    bus_wr(A_PEND, 8'hFF);
    exp_rd(A_PEND, 8'h28, "R5 write ones no change");
    bus_wr(A_PEND, 8'hF7);
    exp_rd(A_PEND, 8'h20, "R5 write zero clears bit3 only");

    // R4: enable after event, level held, drop on clear
    bus_wr(A_EN, 8'h20);
    exp_irq(1'b1, "R4 irq after enable");
    repeat (4) @(negedge clk);
    exp_irq(1'b1, "R4 irq held as level");
    bus_wr(A_PEND, 8'hDF);
    exp_irq(1'b0, "R4 irq drops after clear");
    bus_wr(A_EN, 8'h01);
    set_line(0, 1'b0);                          // bit1 pending, not enabled
    exp_irq(1'b0, "R4 non-enabled event no irq");
    set_line(0, 1'b1);                          // bit0 enabled
    exp_irq(1'b1, "R4 enabled event raises irq");

    // R6: second fall lands with a full clear in the same cycle
    @(negedge clk);
    line_n[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    addr = A_PEND; wdata = 8'h00; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    exp_rd(A_PEND, 8'h02, "R6 edge beats clear");
    bus_wr(A_PEND, 8'h00);
    bus_wr(A_EN, 8'h00);
    line_n[1] = 1'b1; line_n[2] = 1'b1;

    // R9: level held low through reset release
    @(negedge clk);
    line_n = 4'b0111;
    do_reset();
    repeat (8) @(negedge clk);
    exp_rd(A_PEND, 8'h00, "R9 held level not an event");
    set_line(3, 1'b1);
    exp_rd(A_PEND, 8'h40, "R9 first change after window");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule